// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory. Software first sets the ring base. Later, while the controller enable input is high, it writes the transmit-activate register. The walker then fetches the descriptor at its current pointer. If that descriptor is marked ready, the walker reads the buffer it points to and moves the next descriptor pointer on. It keeps doing this until it meets a descriptor that is not ready. It then goes idle.

Each descriptor is eight bytes long and is read as two 32-bit words. The first word carries a 16-bit flag field in its upper half and a 16-bit byte count in its lower half. The second word carries the buffer address. Bytes from consecutive buffers join into a single frame until a buffer marked last is consumed. A frame is capped at a parameterised maximum size. The bytes leave on a valid/ready byte stream, and the final byte of a frame carries an end marker. After each buffer, the walker writes the first descriptor word back with the ready flag cleared. It also pulses one or more event outputs.

Top module: `txr_engine`

## Requirements
- R1: After reset no descriptor or buffer request is pending, tx_valid, ev_buf, ev_frame and ev_babble are low, and the ring base reads as zero.
- R2: A write to register offset 0x014 starts a walk only while ctrl_en is 1. With ctrl_en at 0 the write issues no descriptor request. Reading offset 0x014 always returns zero.
- R3: A write to offset 0x184 stores the value with bits 1:0 forced to zero, and that value reads back at 0x184. The next walk then starts from that base.
- R4: Each descriptor is fetched as two reads: first at the pointer, then at pointer+4. In the first word, bits 31:16 are the flags and bits 15:0 the byte count. The second word is the buffer address. If flag bit 15 (ready) is 0, the walker stops with no write and no event.
- R5: A ready buffer yields its bytes in address order, from the buffer address up to the address plus count minus one, on tx_data. tx_last is set only on the final byte of a buffer whose flag bit 11 (last) is 1.
- R6: Buffers without the last flag extend the same frame, so their bytes come out with tx_last low.
- R7: Each consumed descriptor gets exactly one write, to its own address. The write data has flags in bits 31:16 with bit 15 cleared and all other flag bits kept, and the original byte count in bits 15:0.
- R8: ev_buf pulses for one cycle per consumed descriptor. ev_frame pulses in the same cycle when that descriptor has the last flag.
- R9: When flag bit 13 (wrap) is 1, the next fetch is at the ring base. Otherwise it is at the pointer plus 8.
- R10: A frame never exceeds MAX_FRAME bytes. A buffer that would pass the cap is cut to fit, and ev_babble pulses once for that buffer. The byte total restarts at zero after each last buffer.
- R11: An activate write that arrives while a walk is in progress is remembered. After the walk stops, the walker fetches again at its current pointer.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; gates activate writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr |
| dsc_req | output | 1 | Descriptor access request |
| dsc_we | output | 1 | Descriptor access is a write |
| dsc_addr | output | AW | Descriptor word address |
| dsc_wdata | output | 32 | Descriptor write word |
| dsc_ack | input | 1 | Descriptor access completes this cycle |
| dsc_rdata | input | 32 | Descriptor read word, valid with dsc_ack |
| buf_req | output | 1 | Buffer byte read request |
| buf_addr | output | AW | Buffer byte address |
| buf_ack | input | 1 | Buffer read completes this cycle |
| buf_rdata | input | 8 | Buffer byte, valid with buf_ack |
| tx_valid | output | 1 | Frame byte available |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| ev_buf | output | 1 | Buffer consumed pulse |
| ev_frame | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame cap reached pulse |

## Verification
The bench builds the walker with MAX_FRAME set to 20 and leaves every other parameter at its default. With that cap, a single buffer of a few dozen bytes, or two buffers of moderate length, hit the clipping path. The frame total is also seen to restart on the following frame. A four-slot ring with the wrap flag on its last slot brings the return to the base into the first few frames. Random stalls on buffer reads and on the sink show that multi-buffer joining and the end marker survive back-pressure.

// File: rtl/txr_pkg.sv
package txr_pkg;
   // descriptor word split: flags in the upper half, byte count in the lower half
   localparam int FLD_W      = 16;
   localparam int FLAG_READY = 15;
   localparam int FLAG_WRAP  = 13;
   localparam int FLAG_LAST  = 11;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HEAD,
      S_PTR,
      S_MOVE,
      S_SEAL,
      S_BACK
   } txr_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
   parameter int AW       = 32,
   parameter int RA_W     = 10,
   parameter int OFS_ACT  = 'h014,
   parameter int OFS_BASE = 'h184
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_en,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [AW-1:0]   reg_wdata,
   output logic [AW-1:0]   reg_rdata,
   output logic [AW-1:0]   base_q,
   output logic            base_wr,
   output logic            act_go
);
   localparam logic [RA_W-1:0] A_ACT  = RA_W'(OFS_ACT);
   localparam logic [RA_W-1:0] A_BASE = RA_W'(OFS_BASE);

   if (OFS_ACT == OFS_BASE) begin : g_bad_ofs
      $error("txr_regs: register offsets collide");
   end
   if ((OFS_ACT % 4) != 0 || (OFS_BASE % 4) != 0) begin : g_bad_align
      $error("txr_regs: register offsets must be word aligned");
   end
   if (AW < 8) begin : g_bad_aw
      $error("txr_regs: address width too small");
   end

   assign base_wr = reg_we && (reg_addr == A_BASE);
   assign act_go  = reg_we && (reg_addr == A_ACT) && ctrl_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_wr) begin
         base_q <= {reg_wdata[AW-1:2], 2'b00};
      end
   end

   // the activate register has no storage and reads as zero
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_BASE) reg_rdata = base_q;
   end
endmodule

// File: rtl/txr_stream.sv
module txr_stream #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          close,
   output logic          space,
   output logic          empty,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   output logic          tx_last,
   input  logic          tx_ready
);
   logic          hold_v;
   logic [DW-1:0] hold_d;
   logic          o_v;
   logic [DW-1:0] o_d;
   logic          o_l;

   if (DW < 1) begin : g_bad_dw
      $error("txr_stream: data width must be positive");
   end

   // one byte is kept back until it is known whether it ends the frame
   assign space    = !(hold_v && o_v);
   assign empty    = !hold_v && !o_v;
   assign tx_valid = o_v;
   assign tx_data  = o_d;
   assign tx_last  = o_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
         o_v    <= 1'b0;
         o_d    <= '0;
         o_l    <= 1'b0;
      end else begin
         if (o_v && tx_ready) o_v <= 1'b0;
         if (push) begin
            if (hold_v) begin
               o_v <= 1'b1;
               o_d <= hold_d;
               o_l <= 1'b0;
            end
            hold_d <= push_data;
            hold_v <= 1'b1;
         end else if (close && hold_v && (!o_v || tx_ready)) begin
            o_v    <= 1'b1;
            o_d    <= hold_d;
            o_l    <= 1'b1;
            hold_v <= 1'b0;
         end
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R12
   AST_LAST_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_last) |-> !hold_v); // R5
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
   import txr_pkg::*;
#(
   parameter int AW        = 32,
   parameter int MAX_FRAME = 2032,
   parameter int DESC_STEP = 8,
   parameter int BUS_SWAP  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_go,
   input  logic          base_wr,
   input  logic [AW-1:0] base_q,
   output logic          dsc_req,
   output logic          dsc_we,
   output logic [AW-1:0] dsc_addr,
   output logic [31:0]   dsc_wdata,
   input  logic          dsc_ack,
   input  logic [31:0]   dsc_rdata,
   output logic          buf_req,
   output logic [AW-1:0] buf_addr,
   input  logic          buf_ack,
   output logic          st_push,
   output logic          st_close,
   input  logic          st_space,
   input  logic          st_empty,
   output logic          ev_buf,
   output logic          ev_frame,
   output logic          ev_babble
);
   localparam int              CW     = $clog2(MAX_FRAME + 1);
   localparam logic [CW-1:0]   MAX_C  = CW'(MAX_FRAME);
   localparam logic [AW-1:0]   STEP_A = AW'(DESC_STEP);
   localparam logic [AW-1:0]   FOUR_A = AW'(4);
   localparam logic [FLD_W-1:0] RDY_M = FLD_W'(1) << FLAG_READY;

   if (MAX_FRAME < 1 || MAX_FRAME >= (1 << FLD_W)) begin : g_bad_max
      $error("txr_ctrl: frame cap must fit the byte count field");
   end
   if (DESC_STEP < 8 || (DESC_STEP % 4) != 0) begin : g_bad_step
      $error("txr_ctrl: descriptor stride must be a word multiple of at least 8");
   end
   if (AW > 32 || AW < 8) begin : g_bad_aw
      $error("txr_ctrl: address width must lie in 8..32");
   end

   txr_state_e       st_q;
   logic [AW-1:0]    ptr_q;
   logic [FLD_W-1:0] flg_q;
   logic [FLD_W-1:0] len_q;
   logic [AW-1:0]    bptr_q;
   logic [CW-1:0]    xlen_q;
   logic [CW-1:0]    idx_q;
   logic [CW-1:0]    fcnt_q;
   logic             go_q;
   logic             reload_q;

   logic [31:0]      rd_w;
   logic [31:0]      wb_w;
   logic [CW-1:0]    room;
   logic             clip;

   // bus byte order variant
   if (BUS_SWAP != 0) begin : g_swap
      assign rd_w      = {dsc_rdata[7:0], dsc_rdata[15:8], dsc_rdata[23:16], dsc_rdata[31:24]};
      assign dsc_wdata = {wb_w[7:0], wb_w[15:8], wb_w[23:16], wb_w[31:24]};
   end else begin : g_direct
      assign rd_w      = dsc_rdata;
      assign dsc_wdata = wb_w;
   end

   assign wb_w = {flg_q & ~RDY_M, len_q};
   assign room = MAX_C - fcnt_q;
   assign clip = len_q > FLD_W'(room);

   assign dsc_req  = (st_q == S_HEAD) || (st_q == S_PTR) || (st_q == S_BACK);
   assign dsc_we   = (st_q == S_BACK);
   assign dsc_addr = ptr_q + ((st_q == S_PTR) ? FOUR_A : '0);

   assign buf_req  = (st_q == S_MOVE) && st_space && (idx_q != xlen_q);
   assign buf_addr = bptr_q + AW'(idx_q);
   assign st_push  = buf_req && buf_ack;
   assign st_close = (st_q == S_SEAL);

   assign ev_buf    = (st_q == S_BACK) && dsc_ack;
   assign ev_frame  = ev_buf && flg_q[FLAG_LAST];
   assign ev_babble = (st_q == S_PTR) && dsc_ack && clip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         ptr_q    <= '0;
         flg_q    <= '0;
         len_q    <= '0;
         bptr_q   <= '0;
         xlen_q   <= '0;
         idx_q    <= '0;
         fcnt_q   <= '0;
         go_q     <= 1'b0;
         reload_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (reload_q) begin
                  ptr_q    <= base_q;
                  reload_q <= 1'b0;
               end else if (go_q) begin
                  go_q <= 1'b0;
                  st_q <= S_HEAD;
               end
            end
            S_HEAD: begin
               if (dsc_ack) begin
                  flg_q <= rd_w[31:16];
                  len_q <= rd_w[15:0];
                  st_q  <= rd_w[16 + FLAG_READY] ? S_PTR : S_IDLE;
               end
            end
            S_PTR: begin
               if (dsc_ack) begin
                  bptr_q <= rd_w[AW-1:0];
                  xlen_q <= clip ? room : CW'(len_q);
                  idx_q  <= '0;
                  st_q   <= S_MOVE;
               end
            end
            S_MOVE: begin
               if (st_push) begin
                  idx_q  <= idx_q + CW'(1);
                  fcnt_q <= fcnt_q + CW'(1);
               end else if (idx_q == xlen_q) begin
                  st_q <= flg_q[FLAG_LAST] ? S_SEAL : S_BACK;
               end
            end
            S_SEAL: begin
               if (st_empty) st_q <= S_BACK;
            end
            S_BACK: begin
               if (dsc_ack) begin
                  if (flg_q[FLAG_LAST]) fcnt_q <= '0;
                  ptr_q <= flg_q[FLAG_WRAP] ? base_q : (ptr_q + STEP_A);
                  st_q  <= S_HEAD;
               end
            end
            default: st_q <= S_IDLE;
         endcase
         if (act_go)  go_q     <= 1'b1;
         if (base_wr) reload_q <= 1'b1;
      end
   end

   AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt_q <= MAX_C); // R10
   AST_DSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr))); // R4
   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_req && !buf_ack) |=> (buf_req && $stable(buf_addr))); // R5
   AST_DSC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_req |-> (dsc_addr[1:0] == 2'b00)); // R9
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
   parameter int AW        = 32,
   parameter int RA_W      = 10,
   parameter int MAX_FRAME = 2032,
   parameter int DESC_STEP = 8,
   parameter int OFS_ACT   = 'h014,
   parameter int OFS_BASE  = 'h184,
   parameter int BUS_SWAP  = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_en,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [AW-1:0]   reg_wdata,
   output logic [AW-1:0]   reg_rdata,
   output logic            dsc_req,
   output logic            dsc_we,
   output logic [AW-1:0]   dsc_addr,
   output logic [31:0]     dsc_wdata,
   input  logic            dsc_ack,
   input  logic [31:0]     dsc_rdata,
   output logic            buf_req,
   output logic [AW-1:0]   buf_addr,
   input  logic            buf_ack,
   input  logic [7:0]      buf_rdata,
   output logic            tx_valid,
   output logic [7:0]      tx_data,
   output logic            tx_last,
   input  logic            tx_ready,
   output logic            ev_buf,
   output logic            ev_frame,
   output logic            ev_babble
);
   logic [AW-1:0] base_q;
   logic          base_wr;
   logic          act_go;
   logic          st_push;
   logic          st_close;
   logic          st_space;
   logic          st_empty;

   txr_regs #(
      .AW(AW), .RA_W(RA_W), .OFS_ACT(OFS_ACT), .OFS_BASE(OFS_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .base_q(base_q), .base_wr(base_wr), .act_go(act_go)
   );

   txr_ctrl #(
      .AW(AW), .MAX_FRAME(MAX_FRAME), .DESC_STEP(DESC_STEP), .BUS_SWAP(BUS_SWAP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .act_go(act_go), .base_wr(base_wr), .base_q(base_q),
      .dsc_req(dsc_req), .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
      .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata),
      .buf_req(buf_req), .buf_addr(buf_addr), .buf_ack(buf_ack),
      .st_push(st_push), .st_close(st_close), .st_space(st_space), .st_empty(st_empty),
      .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble)
   );

   txr_stream #(
      .DW(8)
   ) u_stream (
      .clk(clk), .rst_n(rst_n), .push(st_push), .push_data(buf_rdata),
      .close(st_close), .space(st_space), .empty(st_empty),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
   );
endmodule

// File: tb/txr_engine_tb.sv
module txr_engine_tb;
   localparam int MAXF = 20;
   // {count[7:0], buffer low byte[7:0], expected bytes[7:0], babble}
   localparam logic [24:0] VEC [6] = '{
      {8'd4,  8'h10, 8'd4,  1'b0},
      {8'd1,  8'h20, 8'd1,  1'b0},
      {8'd20, 8'h30, 8'd20, 1'b0},
      {8'd27, 8'h40, 8'd20, 1'b1},
      {8'd0,  8'h50, 8'd0,  1'b0},
      {8'd7,  8'hF0, 8'd7,  1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b0;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dsc_req, dsc_we, dsc_ack;
   logic [31:0] dsc_addr, dsc_wdata, dsc_rdata;
   logic        buf_req, buf_ack;
   logic [31:0] buf_addr;
   logic [7:0]  buf_rdata;
   logic        tx_valid, tx_last, tx_ready;
   logic [7:0]  tx_data;
   logic        ev_buf, ev_frame, ev_babble;

   logic [31:0] dmem [0:255];
   logic [7:0]  lf = 8'h01;
   logic        force_low = 1'b0;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int rd_cnt, wb_cnt, n_buf, n_frm, n_bab, cap_n, exp_n, watch_rd, hold_err;
   logic [31:0] first_rd, last_rd, wb_addr, wb_data, watch_addr;
   logic        got_first;
   logic [7:0]  cap_d [0:63];
   logic        cap_l [0:63];
   logic [7:0]  exp_d [0:63];
   logic        exp_l [0:63];
   logic        pv, pl;
   logic [7:0]  pd;
   logic [31:0] ring_base;
   int          slot;

   always #10 clk = ~clk;

   txr_engine #(.MAX_FRAME(MAXF)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dsc_req(dsc_req), .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
      .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata),
      .buf_req(buf_req), .buf_addr(buf_addr), .buf_ack(buf_ack), .buf_rdata(buf_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble)
   );

   assign dsc_ack   = dsc_req;
   assign dsc_rdata = dmem[dsc_addr[9:2]];
   assign buf_ack   = buf_req && (lf[0] || lf[3]);
   assign buf_rdata = buf_addr[7:0] ^ 8'hA5;
   assign tx_ready  = !force_low && (lf[2] || lf[6]);

   always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 100000) begin
         n_chk = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (dsc_req && !dsc_we) begin
            rd_cnt = rd_cnt + 1;
            if (!got_first) begin first_rd = dsc_addr; got_first = 1'b1; end
            if (dsc_addr[2] == 1'b0) last_rd = dsc_addr;
            if (dsc_addr == watch_addr) watch_rd = watch_rd + 1;
         end
         if (dsc_req && dsc_we) begin
            dmem[dsc_addr[9:2]] = dsc_wdata;
            wb_cnt = wb_cnt + 1;
            wb_addr = dsc_addr;
            wb_data = dsc_wdata;
         end
         if (ev_buf) n_buf = n_buf + 1;
         if (ev_frame) n_frm = n_frm + 1;
         if (ev_babble) n_bab = n_bab + 1;
         if (pv && !pl && !(tx_valid && tx_data == pd && tx_last == pl)) hold_err = hold_err + 1;
         if (pv && pl && !(tx_valid && tx_data == pd && tx_last)) hold_err = hold_err + 1;
         if (tx_valid && tx_ready) begin
            if (cap_n < 64) begin cap_d[cap_n] = tx_data; cap_l[cap_n] = tx_last; end
            cap_n = cap_n + 1;
         end
         pv = tx_valid && !tx_ready;
         pd = tx_data;
         pl = tx_last;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      rd_cnt = 0; wb_cnt = 0; n_buf = 0; n_frm = 0; n_bab = 0;
      cap_n = 0; exp_n = 0; watch_rd = 0; got_first = 1'b0;
      first_rd = '1; last_rd = '1; wb_addr = '1; wb_data = '1;
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = '0;
   endtask

   task automatic put_desc(input int s, input logic [15:0] f, input logic [15:0] n, input logic [31:0] bp);
      logic [31:0] a;
      a = ring_base + 32'(8 * s);
      dmem[a[9:2]] = {f, n};
      dmem[a[9:2] + 8'd1] = bp;
   endtask

   task automatic expect_buf(input logic [31:0] bp, input int n, input bit last);
      for (int k = 0; k < n; k++) begin
         exp_d[exp_n] = 8'(bp + 32'(k)) ^ 8'hA5;
         exp_l[exp_n] = last && (k == n - 1);
         exp_n = exp_n + 1;
      end
   endtask

   task automatic cmp_stream(input string tag);
      int bad;
      bad = 0;
      chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
      for (int k = 0; k < exp_n && k < cap_n; k++)
         if (cap_d[k] !== exp_d[k] || cap_l[k] !== exp_l[k]) bad = bad + 1;
      chk(bad == 0, {tag, " byte content/last marker mismatches"}, bad, 0);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] slot_addr(input int s);
      return ring_base + 32'(8 * s);
   endfunction

   initial begin
      logic [31:0] r;
      logic [7:0]  d0;
      logic [15:0] flg;
      int          ln, nb, bb;
      logic [31:0] bp;
      for (int i = 0; i < 256; i++) dmem[i] = '0;
      pv = 1'b0; pd = '0; pl = 1'b0; hold_err = 0;
      watch_addr = '1;
      clr();
      ring_base = 32'h100;
      slot = 0;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 reset state
      chk(!dsc_req && !buf_req, "R1 no request after reset", int'(dsc_req) + int'(buf_req), 0);
      chk(!tx_valid && !ev_buf && !ev_frame && !ev_babble, "R1 outputs low after reset",
          int'(tx_valid), 0);
      rd(10'h184, r);
      chk(r == 32'h0, "R1 ring base reads zero", int'(r), 0);

      // R3 base write alignment
      wr(10'h184, 32'h103);
      rd(10'h184, r);
      chk(r == 32'h100, "R3 base low bits forced to zero", int'(r), 32'h100);

      // R2 activate ignored while disabled; activate reads zero
      put_desc(0, 16'h8800, 16'd4, 32'h10);
      wait_cyc(2);
      clr();
      wr(10'h014, 32'hFFFF_FFFF);
      wait_cyc(30);
      chk(rd_cnt == 0, "R2 no fetch while disabled", rd_cnt, 0);
      rd(10'h014, r);
      chk(r == 32'h0, "R2 activate register reads zero", int'(r), 0);
      ctrl_en = 1'b1;

      // table of single-buffer frames (R4 R5 R7 R8 R9 R10)
      for (int v = 0; v < 6; v++) begin
         ln = int'(VEC[v][24:17]);
         bp = {24'h0, VEC[v][16:9]};
         nb = int'(VEC[v][8:1]);
         bb = int'(VEC[v][0]);
         flg = (slot == 3) ? 16'hA800 : 16'h8800;
         put_desc(slot, flg, 16'(ln), bp);
         clr();
         expect_buf(bp, nb, 1'b1);
         wr(10'h014, 32'h0);
         wait_cyc(200);
         chk(first_rd == slot_addr(slot), "R4 fetch at current slot", int'(first_rd), int'(slot_addr(slot)));
         chk(last_rd == slot_addr((slot + 1) % 4), "R9 next fetch address (wrap or +8)",
             int'(last_rd), int'(slot_addr((slot + 1) % 4)));
         cmp_stream("R5 table frame");
         chk(wb_cnt == 1 && wb_addr == slot_addr(slot), "R7 single writeback to own address",
             int'(wb_addr), int'(slot_addr(slot)));
         chk(wb_data == {flg & 16'h7FFF, 16'(ln)}, "R7 writeback word", int'(wb_data),
             int'({flg & 16'h7FFF, 16'(ln)}));
         chk(n_buf == 1 && n_frm == 1, "R8 buffer and frame events", n_buf * 10 + n_frm, 11);
         chk(n_bab == bb, "R10 babble event count", n_bab, bb);
         slot = (slot + 1) % 4;
      end

      // R6 three-buffer frame across the wrap
      put_desc(slot, 16'h8000, 16'd3, 32'h60);
      put_desc((slot + 1) % 4, 16'hA000, 16'd4, 32'h70);
      put_desc((slot + 2) % 4, 16'h8800, 16'd2, 32'h80);
      clr();
      expect_buf(32'h60, 3, 1'b0);
      expect_buf(32'h70, 4, 1'b0);
      expect_buf(32'h80, 2, 1'b1);
      wr(10'h014, 32'h0);
      wait_cyc(200);
      cmp_stream("R6 multi-buffer frame");
      chk(n_buf == 3 && wb_cnt == 3, "R8 one buffer event per descriptor", n_buf, 3);
      chk(n_frm == 1 && n_bab == 0, "R6 single frame event", n_frm, 1);
      slot = (slot + 3) % 4;

      // R10 clip across two buffers
      put_desc(slot, 16'h8000, 16'd15, 32'h90);
      put_desc((slot + 1) % 4, 16'h8800, 16'd10, 32'hB0);
      clr();
      expect_buf(32'h90, 15, 1'b0);
      expect_buf(32'hB0, 5, 1'b1);
      wr(10'h014, 32'h0);
      wait_cyc(200);
      cmp_stream("R10 clipped frame");
      chk(n_bab == 1, "R10 one babble event", n_bab, 1);
      chk(wb_data == {16'h0800, 16'd10}, "R7 clipped buffer keeps original count", int'(wb_data),
          int'({16'h0800, 16'd10}));

      // R3 new base reloads the pointer
      wr(10'h184, 32'h140);
      ring_base = 32'h140;
      put_desc(0, 16'h8800, 16'd6, 32'hC0);
      wait_cyc(3);
      clr();
      expect_buf(32'hC0, 6, 1'b1);
      wr(10'h014, 32'h0);
      wait_cyc(150);
      chk(first_rd == 32'h140, "R3 walk restarts at new base", int'(first_rd), 32'h140);
      cmp_stream("R3 frame from new ring");

      // R11 activation during a walk; R12 hold under stall
      put_desc(1, 16'h8800, 16'd12, 32'hD0);
      clr();
      watch_addr = slot_addr(2);
      expect_buf(32'hD0, 12, 1'b1);
      force_low = 1'b1;
      wr(10'h014, 32'h0);
      wait_cyc(40);
      d0 = tx_data;
      chk(tx_valid == 1'b1, "R12 byte waiting under stall", int'(tx_valid), 1);
      wait_cyc(6);
      chk(tx_valid && tx_data == d0, "R12 byte held under stall", int'(tx_data), int'(d0));
      wr(10'h014, 32'h0);
      force_low = 1'b0;
      wait_cyc(200);
      chk(watch_rd == 2, "R11 stop slot fetched again", watch_rd, 2);
      cmp_stream("R10 total restarted after last buffer");

      // R4 stop on a descriptor that is not ready
      clr();
      wr(10'h014, 32'h0);
      wait_cyc(30);
      chk(rd_cnt == 1, "R4 single fetch of idle slot", rd_cnt, 1);
      chk(wb_cnt == 0 && n_buf == 0 && n_frm == 0 && cap_n == 0, "R4 no write or event on stop",
          wb_cnt + n_buf + n_frm + cap_n, 0);

      chk(hold_err == 0, "R12 stream stable while stalled", hold_err, 0);

      summary();
      $finish;
   end
endmodule